// File: doc/BRIEF.md
# Indirect register-file access unit

This block sits between a processor core's data-path port and a banked 512-entry data register file and supplies pointer-based indirect access. It owns an 8-bit pointer register and takes a one-bit bank select from the core. Each location within a bank is named by the low seven bits of the 9-bit address. One of these locations, the indirect port, is virtual. Any access to it is redirected to the register whose 9-bit effective address is the bank select bit placed above the pointer.

Every other address passes straight through to the register file, except the pointer location. The pointer location is held inside the block and is seen at the same place in every bank. An indirect access that resolves back onto the indirect port reads as 00h and cannot write anything. Reads are combinational from the resolved address. Writes take effect at the rising clock edge while the write enable is high.

Each access is sorted into one of three routes: FILE, SELF and POINTER. A route applies only for the cycle the address is presented. The only stored state is the pointer register, and reset puts it at 00h.

Top module: `ira_unit`

## Requirements
- R1: A core access to a location whose bank-relative part is neither 00h nor 04h is passed through unchanged. The register-file address equals the core address, the write enable and write data are forwarded as they are, and the read data is the register-file data.
- R2: A core access to bank-relative location 00h in any bank is an indirect access. Unless R3 or R5 applies, it reaches the register-file entry at {bank select, pointer}, for reads and for writes.
- R3: When the effective indirect address has bank-relative part 00h, the indirect access reads 00h and issues no register-file write.
- R4: Bank-relative location 04h in every bank is the pointer register. A read returns the pointer. A write loads the core write data into the pointer at the clock edge. Neither kind of access issues a register-file write.
- R5: When an indirect access resolves to bank-relative location 04h, it reads and writes the pointer register exactly as R4 describes.
- R6: Reset clears the pointer to 00h.
- R7: A pointer value written at one clock edge steers the very next indirect access. For example, moving the pointer from 25h to 26h switches the indirect read from register 25h to register 26h.
- R8: The bank select bit takes effect combinationally. Changing it alters the indirect target with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pointer writes and register-file writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset; clears the pointer |
| ibank_i | input | 1 | Bank select bit that forms the top bit of the effective indirect address |
| core_addr_i | input | 9 | Direct address from the core, including its bank bits |
| core_we_i | input | 1 | Core write enable |
| core_wdata_i | input | 8 | Core write data |
| core_rdata_o | output | 8 | Read data returned to the core |
| rf_addr_o | output | 9 | Register-file address |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data (combinational) |

## Verification
The assertions assume that the pointer location and the indirect port sit at different bank-relative locations. They also assume that the core address, write enable and write data are known and steady around each rising edge, and that no write is requested while reset is held. The bench meets these conditions. It drives every input only on the falling edge and holds the write enable low throughout reset. It also preloads every register-file entry it later reads through direct writes, so no indirect read returns an unwritten location.

// File: rtl/ira_pkg.sv
package ira_pkg;

    // Route chosen for the access presented in the current cycle
    typedef enum logic [1:0] {
        ROUTE_FILE    = 2'd0,   // ordinary register-file entry
        ROUTE_SELF    = 2'd1,   // indirect access folded onto the indirect port
        ROUTE_POINTER = 2'd2    // pointer register held in this block
    } route_t;

endpackage

// File: rtl/ira_decode.sv
module ira_decode
    import ira_pkg::*;
#(
    parameter int BANK_W   = 1,
    parameter int PTR_W    = 8,
    parameter int LOC_W    = 7,
    parameter int INDF_LOC = 0,
    parameter int PTR_LOC  = 4,
    localparam int ADDR_W  = BANK_W + PTR_W
) (
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BANK_W-1:0] ibank,
    input  logic [PTR_W-1:0]  ptr,
    output route_t            route,
    output logic [ADDR_W-1:0] tgt_addr
);

    localparam logic [LOC_W-1:0] INDF_L = LOC_W'(INDF_LOC);
    localparam logic [LOC_W-1:0] PTR_L  = LOC_W'(PTR_LOC);

    logic             is_indirect;
    logic [LOC_W-1:0] tgt_loc;

    always_comb begin
        is_indirect = (core_addr[LOC_W-1:0] == INDF_L);
        tgt_addr    = is_indirect ? {ibank, ptr} : core_addr;
        tgt_loc     = tgt_addr[LOC_W-1:0];

        // The indirect port can only be reached through the pointer here,
        // since a direct access to it was already redirected above.
        if (tgt_loc == INDF_L) begin
            route = ROUTE_SELF;
        end else if (tgt_loc == PTR_L) begin
            route = ROUTE_POINTER;
        end else begin
            route = ROUTE_FILE;
        end
    end

endmodule

// File: rtl/ira_pointer.sv
module ira_pointer #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] ptr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (we) begin
            ptr_q <= wdata;
        end
    end

endmodule

// File: rtl/ira_steer.sv
module ira_steer
    import ira_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input  route_t            route,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] core_rdata,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              ptr_we,
    output logic [PTR_W-1:0]  ptr_wdata
);

    always_comb begin
        rf_addr    = tgt_addr;
        rf_wdata   = core_wdata;
        ptr_wdata  = PTR_W'(core_wdata);
        rf_we      = 1'b0;
        ptr_we     = 1'b0;
        core_rdata = '0;
        unique case (route)
            ROUTE_FILE: begin
                rf_we      = core_we;
                core_rdata = rf_rdata;
            end
            ROUTE_SELF: begin
                core_rdata = '0;
            end
            ROUTE_POINTER: begin
                ptr_we     = core_we;
                core_rdata = DATA_W'(ptr);
            end
            default: begin
                core_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/ira_unit.sv
module ira_unit
    import ira_pkg::*;
#(
    parameter int BANK_W   = 1,
    parameter int PTR_W    = 8,
    parameter int DATA_W   = 8,
    parameter int LOC_W    = 7,
    parameter int INDF_LOC = 0,
    parameter int PTR_LOC  = 4,
    localparam int ADDR_W  = BANK_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] ibank_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic              core_we_i,
    input  logic [DATA_W-1:0] core_wdata_i,
    output logic [DATA_W-1:0] core_rdata_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic              rf_we_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    input  logic [DATA_W-1:0] rf_rdata_i
);

    route_t            route;
    logic [ADDR_W-1:0] tgt_addr;
    logic [PTR_W-1:0]  ptr_q;
    logic              ptr_we;
    logic [PTR_W-1:0]  ptr_wdata;

    ira_decode #(
        .BANK_W  (BANK_W),
        .PTR_W   (PTR_W),
        .LOC_W   (LOC_W),
        .INDF_LOC(INDF_LOC),
        .PTR_LOC (PTR_LOC)
    ) u_decode (
        .core_addr(core_addr_i),
        .ibank    (ibank_i),
        .ptr      (ptr_q),
        .route    (route),
        .tgt_addr (tgt_addr)
    );

    ira_steer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .PTR_W (PTR_W)
    ) u_steer (
        .route     (route),
        .tgt_addr  (tgt_addr),
        .core_we   (core_we_i),
        .core_wdata(core_wdata_i),
        .rf_rdata  (rf_rdata_i),
        .ptr       (ptr_q),
        .core_rdata(core_rdata_o),
        .rf_addr   (rf_addr_o),
        .rf_we     (rf_we_o),
        .rf_wdata  (rf_wdata_o),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata)
    );

    ira_pointer #(
        .PTR_W(PTR_W)
    ) u_pointer (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ptr_we),
        .wdata(ptr_wdata),
        .ptr_q(ptr_q)
    );

endmodule

// File: rtl/ira_unit_chk.sv
module ira_unit_chk #(
    parameter int BANK_W   = 1,
    parameter int PTR_W    = 8,
    parameter int DATA_W   = 8,
    parameter int LOC_W    = 7,
    parameter int INDF_LOC = 0,
    parameter int PTR_LOC  = 4,
    localparam int ADDR_W  = BANK_W + PTR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] ibank_i,
    input logic [ADDR_W-1:0] core_addr_i,
    input logic              core_we_i,
    input logic [DATA_W-1:0] core_wdata_i,
    input logic [DATA_W-1:0] core_rdata_o,
    input logic [ADDR_W-1:0] rf_addr_o,
    input logic              rf_we_o,
    input logic [PTR_W-1:0]  ptr_q
);

    localparam logic [LOC_W-1:0] INDF_L = LOC_W'(INDF_LOC);
    localparam logic [LOC_W-1:0] PTR_L  = LOC_W'(PTR_LOC);

    logic [LOC_W-1:0] cloc;
    logic [LOC_W-1:0] ploc;
    logic             ind;
    logic             ind_file;
    logic             ind_self;
    logic             ptr_hit;
    logic             plain;

    assign cloc     = core_addr_i[LOC_W-1:0];
    assign ploc     = ptr_q[LOC_W-1:0];
    assign ind      = (cloc == INDF_L);
    assign ind_self = ind && (ploc == INDF_L);
    assign ind_file = ind && (ploc != INDF_L) && (ploc != PTR_L);
    assign ptr_hit  = (cloc == PTR_L) || (ind && ploc == PTR_L);
    assign plain    = (cloc != INDF_L) && (cloc != PTR_L);

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n) plain |-> (rf_addr_o == core_addr_i && rf_we_o == core_we_i)); // R1
    AST_INDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) ind_file |-> (rf_addr_o == {ibank_i, ptr_q} && rf_we_o == core_we_i)); // R2
    AST_SELF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ind_self |-> (core_rdata_o == '0 && !rf_we_o)); // R3
    AST_POINTER_NO_FILE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ptr_hit |-> !rf_we_o); // R4
    AST_POINTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ptr_hit && core_we_i) |=> (ptr_q == PTR_W'($past(core_wdata_i)))); // R5
    AST_POINTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(ptr_hit && core_we_i) |=> $stable(ptr_q)); // R7

endmodule

bind ira_unit ira_unit_chk #(
    .BANK_W  (BANK_W),
    .PTR_W   (PTR_W),
    .DATA_W  (DATA_W),
    .LOC_W   (LOC_W),
    .INDF_LOC(INDF_LOC),
    .PTR_LOC (PTR_LOC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ibank_i     (ibank_i),
    .core_addr_i (core_addr_i),
    .core_we_i   (core_we_i),
    .core_wdata_i(core_wdata_i),
    .core_rdata_o(core_rdata_o),
    .rf_addr_o   (rf_addr_o),
    .rf_we_o     (rf_we_o),
    .ptr_q       (ptr_q)
);

// File: tb/sim_ira_unit.sv
module sim_ira_unit;

    logic       clk          = 1'b0;
    logic       rst_n        = 1'b0;
    logic [0:0] ibank_i      = 1'b0;
    logic [8:0] core_addr_i  = 9'h001;
    logic       core_we_i    = 1'b0;
    logic [7:0] core_wdata_i = 8'h00;
    logic [7:0] core_rdata_o;
    logic [8:0] rf_addr_o;
    logic       rf_we_o;
    logic [7:0] rf_wdata_o;
    logic [7:0] rf_rdata_i;

    logic [7:0] rf_mem [512];

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    always_ff @(posedge clk) begin
        if (rf_we_o) rf_mem[rf_addr_o] <= rf_wdata_o;
    end
    assign rf_rdata_i = rf_mem[rf_addr_o];

    ira_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ibank_i     (ibank_i),
        .core_addr_i (core_addr_i),
        .core_we_i   (core_we_i),
        .core_wdata_i(core_wdata_i),
        .core_rdata_o(core_rdata_o),
        .rf_addr_o   (rf_addr_o),
        .rf_we_o     (rf_we_o),
        .rf_wdata_o  (rf_wdata_o),
        .rf_rdata_i  (rf_rdata_i)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: drive at falling edge, commit at the rising edge, release.
    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        core_addr_i  = a;
        core_wdata_i = d;
        core_we_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        core_we_i    = 1'b0;
        core_addr_i  = 9'h001;
    endtask

    // Read: drive at falling edge, sample mid low phase.
    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        core_addr_i = a;
        core_we_i   = 1'b0;
        #5;
        d = core_rdata_o;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(9'h004, v); check("R6 pointer after reset", 16'(v), 16'h00);
        rd(9'h000, v); check("R3 indirect with pointer 00h", 16'(v), 16'h00);
    endtask

    task automatic t_direct();
        logic [7:0] v;
        @(negedge clk);
        core_addr_i = 9'h025; core_wdata_i = 8'h10; core_we_i = 1'b1;
        #5;
        check("R1 forwarded address", 16'(rf_addr_o), 16'h025);
        check("R1 forwarded write enable", 16'(rf_we_o), 16'h1);
        @(posedge clk);
        @(negedge clk);
        core_we_i = 1'b0;
        wr(9'h026, 8'h0A);
        wr(9'h125, 8'h77);
        rd(9'h025, v); check("R1 direct read 025h", 16'(v), 16'h10);
        rd(9'h125, v); check("R1 direct read 125h", 16'(v), 16'h77);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        wr(9'h004, 8'h25);
        rd(9'h000, v); check("R7 indirect via pointer 25h", 16'(v), 16'h10);
        wr(9'h004, 8'h26);
        rd(9'h000, v); check("R7 indirect via pointer 26h", 16'(v), 16'h0A);
        rd(9'h080, v); check("R2 indirect port in bank 1", 16'(v), 16'h0A);
        wr(9'h000, 8'h5C);
        rd(9'h026, v); check("R2 indirect write lands in 026h", 16'(v), 16'h5C);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        wr(9'h004, 8'h25);
        @(negedge clk);
        ibank_i = 1'b1; core_addr_i = 9'h000;
        #3;
        check("R8 bank 1 indirect read", 16'(core_rdata_o), 16'h77);
        check("R8 bank 1 effective address", 16'(rf_addr_o), 16'h125);
        ibank_i = 1'b0;
        #3;
        check("R8 bank 0 indirect read without clock", 16'(core_rdata_o), 16'h10);
    endtask

    task automatic t_self();
        logic [7:0] v;
        wr(9'h004, 8'h00);
        rd(9'h000, v); check("R3 self read", 16'(v), 16'h00);
        @(negedge clk);
        core_addr_i = 9'h000; core_wdata_i = 8'hFF; core_we_i = 1'b1;
        #5;
        check("R3 self write issues no file write", 16'(rf_we_o), 16'h0);
        @(posedge clk);
        @(negedge clk);
        core_we_i = 1'b0;
        rd(9'h004, v); check("R3 pointer untouched by self write", 16'(v), 16'h00);
        wr(9'h004, 8'h80);
        rd(9'h000, v); check("R3 pointer 80h also self", 16'(v), 16'h00);
        @(negedge clk);
        ibank_i = 1'b1; wr(9'h004, 8'h00);
        rd(9'h000, v); check("R3 effective 100h is self", 16'(v), 16'h00);
        ibank_i = 1'b0;
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        @(negedge clk);
        core_addr_i = 9'h184; core_wdata_i = 8'h30; core_we_i = 1'b1;
        #5;
        check("R4 pointer write issues no file write", 16'(rf_we_o), 16'h0);
        @(posedge clk);
        @(negedge clk);
        core_we_i = 1'b0;
        rd(9'h004, v); check("R4 pointer seen from bank 0", 16'(v), 16'h30);
        rd(9'h104, v); check("R4 pointer seen from bank 2", 16'(v), 16'h30);
        wr(9'h004, 8'h04);
        rd(9'h000, v); check("R5 indirect read of pointer", 16'(v), 16'h04);
        wr(9'h000, 8'h25);
        rd(9'h004, v); check("R5 indirect write loads pointer", 16'(v), 16'h25);
        rd(9'h000, v); check("R5 new pointer steers next access", 16'(v), 16'h10);
    endtask

    initial begin
        #(20 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_indirect();
        t_bank();
        t_self();
        t_pointer();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule